// File: doc/BRIEF.md
# PLL Clock Controller Register File

This block is the software-visible register bank of a clock control unit. It sits on a simple 32-bit peripheral bus and holds the PLL control words, the bus clock divider settings, the DRAM clock configuration and the low-speed clock select. It does not generate clocks. It models only what a driver observes when it reads and writes the registers.

Stores to the register window are shaped on the way in. Setting the enable bit of any PLL word also sets that word's lock flag in the same store, so a driver polling for lock finds it set on its first read. Update-request bits in the second DDR PLL word and in the DRAM configuration word are always stored as zero. Offsets at or past 0x324, and any access whose two low address bits are not zero, are rejected with an error response and leave the storage untouched. A write to an in-window offset that names no register is still stored, and it raises a one-cycle unimplemented flag.

The bus is always ready, and each request receives a registered response one cycle after it is accepted.

Top module: `ccuClockRegs`

## Requirements
- R1: After reset, the word offsets read back as follows:
  - 0x000 and 0x020 read 0x00001000.
  - 0x008 reads 0x00035514.
  - 0x010, 0x018, 0x030, 0x038 and 0x048 read 0x03006207.
  - 0x028 and 0x02C read 0x00041811.
  - 0x034 reads 0x00001811.
  - 0x040 reads 0x00000515.
  - 0x04C reads 0x00001800.
  - 0x054 reads 0x00001010.
  - 0x058 reads 0x01000000.
  - 0x0F0 reads 0x00000001.
  - 0x0F8 reads 0x0CCCA000.
  - 0x310 reads 0x0000000F.
  - Every other offset below 0x324 reads zero.
- R2: The PLL words are at offsets 0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x02C, 0x030, 0x034, 0x038, 0x040, 0x048 and 0x04C. A write to one of them with bit 31 (enable) set stores bit 28 (lock) as one. When bit 31 is clear, bit 28 is stored exactly as written.
- R3: A write to offset 0x04C always stores bit 30 as zero. The lock rule of R2 still applies to that write.
- R4: A write to offset 0x0F4 always stores bit 16 as zero and stores all other bits as written.
- R5: A write to any other aligned offset below 0x324 stores the data unchanged. This includes 0x054, 0x164 and 0x320, where bit 31 does not set bit 28.
- R6: Any access at an offset from 0x324 to 0x3FC returns read data zero with the error flag set. A write in that range changes no stored word.
- R7: An access with address bits [1:0] not equal to zero returns data zero with the error flag set, and it changes no stored word.
- R8: The unimplemented flag is high in the response to an aligned write below 0x324 at an offset that names no register. The registers are the PLL words plus 0x054, 0x058, 0x088, 0x08C, 0x090, 0x094, 0x0CC, 0x0F0, 0x0F4, 0x0F8, 0x100, 0x164, 0x310 and 0x320. The write is still stored. The flag is low for reads, for error accesses and for writes to named registers.
- R9: `reqReady` is high in every cycle. `rspValid` is high exactly in the cycle after each accepted request. A read issued in the cycle after a write to the same offset returns the new value. The response data of a write is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 10 | Byte address inside the 0x400-byte window |
| reqWdata | input | 32 | Write data |
| reqReady | output | 1 | Request accepted (always high) |
| rspValid | output | 1 | Response present, one cycle after the request |
| rspRdata | output | 32 | Read data (zero for writes and errors) |
| rspErr | output | 1 | Access rejected: out of window or misaligned |
| unimpPulse | output | 1 | Write landed on an offset that names no register |

## Verification
A single write to offset 0x04C can trigger two functions at once: with bits 31 and 30 both set, the lock set and the update-request clear act on the same stored word in the same cycle. The bench issues that write and reads the word back. It expects bit 28 set and bit 30 cleared, with every other bit as written. The second pairing is a store followed at once by a read of the same offset in the next cycle. The bench expects the response to that read to carry the shaped value, which shows the store took effect at the accepting edge.

// File: rtl/ccuRegPkg.sv
package ccuRegPkg;

  localparam int unsigned CcuAddrW = 10;
  localparam int unsigned CcuDataW = 32;
  localparam int unsigned CcuIdxW  = CcuAddrW - 2;
  localparam logic [CcuAddrW-1:0] CcuLimitOff = 10'h324;
  localparam int unsigned CcuWords = int'(CcuLimitOff) / 4;

  localparam int unsigned PllEnBit   = 31;
  localparam int unsigned PllUpdBit  = 30;
  localparam int unsigned PllLockBit = 28;
  localparam int unsigned DramUpdBit = 16;

  localparam logic [CcuAddrW-1:0] DdrPll1Off = 10'h04C;
  localparam logic [CcuAddrW-1:0] DramCfgOff = 10'h0F4;

  typedef struct packed {
    logic               wrStore;
    logic               rdLoad;
    logic               isPll;
    logic               clrPllUpd;
    logic               clrDramUpd;
    logic [CcuIdxW-1:0] wordIdx;
  } ccuStrobeT;

  function automatic logic isPllOff(input logic [CcuAddrW-1:0] off);
    case (off)
      10'h000, 10'h008, 10'h010, 10'h018, 10'h020, 10'h028, 10'h02C,
      10'h030, 10'h034, 10'h038, 10'h040, 10'h048, 10'h04C: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic isNamedOff(input logic [CcuAddrW-1:0] off);
    case (off)
      10'h054, 10'h058, 10'h088, 10'h08C, 10'h090, 10'h094, 10'h0CC,
      10'h0F0, 10'h0F4, 10'h0F8, 10'h100, 10'h164, 10'h310, 10'h320: return 1'b1;
      default: return isPllOff(off);
    endcase
  endfunction

  function automatic logic [CcuDataW-1:0] ccuResetWord(input logic [CcuIdxW-1:0] idx);
    logic [CcuAddrW-1:0] off;
    off = {idx, 2'b00};
    case (off)
      10'h000, 10'h020:                            return 32'h0000_1000;
      10'h008:                                     return 32'h0003_5514;
      10'h010, 10'h018, 10'h030, 10'h038, 10'h048: return 32'h0300_6207;
      10'h028, 10'h02C:                            return 32'h0004_1811;
      10'h034:                                     return 32'h0000_1811;
      10'h040:                                     return 32'h0000_0515;
      10'h04C:                                     return 32'h0000_1800;
      10'h054:                                     return 32'h0000_1010;
      10'h058:                                     return 32'h0100_0000;
      10'h0F0:                                     return 32'h0000_0001;
      10'h0F8:                                     return 32'h0CCC_A000;
      10'h310:                                     return 32'h0000_000F;
      default:                                     return '0;
    endcase
  endfunction

endpackage

// File: rtl/ccuAccessCtrl.sv
module ccuAccessCtrl
  import ccuRegPkg::*;
#(
  parameter int unsigned ADDR_W = CcuAddrW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output ccuStrobeT         strb,
  output logic              rspValid,
  output logic              rspErr,
  output logic              unimpPulse
);

  logic aligned;
  logic inWindow;
  logic accessOk;

  assign aligned  = (reqAddr[1:0] == 2'b00);
  assign inWindow = (reqAddr < CcuLimitOff);
  assign accessOk = reqValid && aligned && inWindow;

  always_comb begin
    strb            = '0;
    strb.wordIdx    = reqAddr[ADDR_W-1:2];
    strb.wrStore    = accessOk && reqWrite;
    strb.rdLoad     = accessOk && !reqWrite;
    strb.isPll      = isPllOff(reqAddr);
    strb.clrPllUpd  = (reqAddr == DdrPll1Off);
    strb.clrDramUpd = (reqAddr == DramCfgOff);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspErr     <= 1'b0;
      unimpPulse <= 1'b0;
    end else begin
      rspValid   <= reqValid;
      rspErr     <= reqValid && !(aligned && inWindow);
      unimpPulse <= accessOk && reqWrite && !isNamedOff(reqAddr);
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R9
  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R9
  AST_ERR_UNIMP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rspErr && unimpPulse)); // R8

endmodule

// File: rtl/ccuRegBank.sv
module ccuRegBank
  import ccuRegPkg::*;
#(
  parameter int unsigned DATA_W    = CcuDataW,
  parameter int unsigned NUM_WORDS = CcuWords
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccuStrobeT         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] regs [NUM_WORDS];
  logic [DATA_W-1:0] shaped;

  always_comb begin
    shaped = wrData;
    if (strb.clrPllUpd)  shaped[PllUpdBit]  = 1'b0;
    if (strb.clrDramUpd) shaped[DramUpdBit] = 1'b0;
    if (strb.isPll && wrData[PllEnBit]) shaped[PllLockBit] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < int'(NUM_WORDS); i++) begin
        regs[i] <= ccuResetWord(CcuIdxW'(i));
      end
      rdData <= '0;
    end else begin
      if (strb.wrStore) regs[strb.wordIdx] <= shaped;
      rdData <= strb.rdLoad ? regs[strb.wordIdx] : '0;
    end
  end

  AST_LOCK_ON_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStore && strb.isPll && wrData[PllEnBit])
      |=> regs[$past(strb.wordIdx)][PllLockBit]); // R2
  AST_PLL_UPD_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStore && strb.clrPllUpd) |=> !regs[$past(strb.wordIdx)][PllUpdBit]); // R3
  AST_DRAM_UPD_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStore && strb.clrDramUpd) |=> !regs[$past(strb.wordIdx)][DramUpdBit]); // R4
  AST_STORE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStore |-> (int'(strb.wordIdx) < int'(NUM_WORDS))); // R6

endmodule

// File: rtl/ccuClockRegs.sv
module ccuClockRegs
  import ccuRegPkg::*;
#(
  parameter int unsigned ADDR_W = CcuAddrW,
  parameter int unsigned DATA_W = CcuDataW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr,
  output logic              unimpPulse
);

  localparam int unsigned NumWords = int'(CcuLimitOff) / (DATA_W / 8);

  ccuStrobeT strb;

  assign reqReady = 1'b1;

  ccuAccessCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .strb       (strb),
    .rspValid   (rspValid),
    .rspErr     (rspErr),
    .unimpPulse (unimpPulse)
  );

  ccuRegBank #(.DATA_W(DATA_W), .NUM_WORDS(NumWords)) u_bank (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (reqWdata),
    .rdData (rspRdata)
  );

  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspRdata == '0)); // R6

endmodule

// File: tb/ccuClockRegs_tb.sv
module ccuClockRegs_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [9:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic        rspErr;
  logic        unimpPulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    logic        unimp;
    string       tag;
  } expT;

  expT expQ[$];

  always #10 clk = ~clk;

  ccuClockRegs u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr),
    .unimpPulse(unimpPulse)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [9:0] addr, input logic [31:0] wd,
                        input logic [31:0] expData, input logic expErr,
                        input logic expUnimp, input string tag);
    expT e;
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = addr;
    reqWdata = wd;
    e.data = expData; e.err = expErr; e.unimp = expUnimp; e.tag = tag;
    expQ.push_back(e);
    #1;
    check(reqReady == 1'b1, {tag, " R9 ready"}, {31'd0, reqReady}, 32'd1);
  endtask

  task automatic rd(input logic [9:0] addr, input logic [31:0] exp, input string tag);
    access(1'b0, addr, 32'd0, exp, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic [9:0] addr, input logic [31:0] d, input logic unimp,
                    input string tag);
    access(1'b1, addr, d, 32'd0, 1'b0, unimp, tag);
  endtask

  task automatic badAccess(input logic w, input logic [9:0] addr, input string tag);
    access(w, addr, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
    reqWrite = 1'b0;
  endtask

  // Monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected response", {31'd0, rspValid}, 32'd0);
      end else begin
        expT e;
        e = expQ.pop_front();
        check(rspRdata == e.data, {e.tag, " data"}, rspRdata, e.data);
        check(rspErr == e.err, {e.tag, " err"}, {31'd0, rspErr}, {31'd0, e.err});
        check(unimpPulse == e.unimp, {e.tag, " unimp"}, {31'd0, unimpPulse},
              {31'd0, e.unimp});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rspValid == 1'b0, "R9 reset rspValid", {31'd0, rspValid}, 32'd0);
    check(rspErr == 1'b0, "R1 reset rspErr", {31'd0, rspErr}, 32'd0);
    rstN = 1'b1;

    // R1 reset values
    rd(10'h000, 32'h0000_1000, "R1 0x000");
    rd(10'h008, 32'h0003_5514, "R1 0x008");
    rd(10'h010, 32'h0300_6207, "R1 0x010");
    rd(10'h018, 32'h0300_6207, "R1 0x018");
    rd(10'h020, 32'h0000_1000, "R1 0x020");
    rd(10'h028, 32'h0004_1811, "R1 0x028");
    rd(10'h02C, 32'h0004_1811, "R1 0x02C");
    rd(10'h030, 32'h0300_6207, "R1 0x030");
    rd(10'h034, 32'h0000_1811, "R1 0x034");
    rd(10'h038, 32'h0300_6207, "R1 0x038");
    rd(10'h040, 32'h0000_0515, "R1 0x040");
    rd(10'h048, 32'h0300_6207, "R1 0x048");
    rd(10'h04C, 32'h0000_1800, "R1 0x04C");
    rd(10'h054, 32'h0000_1010, "R1 0x054");
    rd(10'h058, 32'h0100_0000, "R1 0x058");
    rd(10'h0F0, 32'h0000_0001, "R1 0x0F0");
    rd(10'h0F8, 32'h0CCC_A000, "R1 0x0F8");
    rd(10'h310, 32'h0000_000F, "R1 0x310");
    rd(10'h088, 32'h0000_0000, "R1 0x088");
    rd(10'h0F4, 32'h0000_0000, "R1 0x0F4");
    rd(10'h320, 32'h0000_0000, "R1 0x320");

    // R2 lock on enable, back-to-back read (R9)
    wr(10'h000, 32'h8000_1000, 1'b0, "R2 wr 0x000");
    rd(10'h000, 32'h9000_1000, "R2 R9 lock set 0x000");
    wr(10'h010, 32'h0000_6207, 1'b0, "R2 wr 0x010");
    rd(10'h010, 32'h0000_6207, "R2 no enable 0x010");
    wr(10'h018, 32'h1000_0000, 1'b0, "R2 wr 0x018");
    rd(10'h018, 32'h1000_0000, "R2 lock as written 0x018");

    // R3 second DDR PLL word
    wr(10'h04C, 32'hC000_1800, 1'b0, "R3 wr 0x04C");
    rd(10'h04C, 32'h9000_1800, "R3 upd clear + lock");
    wr(10'h04C, 32'h4000_0000, 1'b0, "R3 wr 0x04C upd only");
    rd(10'h04C, 32'h0000_0000, "R3 upd only cleared");

    // R4 DRAM config
    wr(10'h0F4, 32'hFFFF_FFFF, 1'b0, "R4 wr 0x0F4");
    rd(10'h0F4, 32'hFFFE_FFFF, "R4 bit16 cleared");

    // R5 plain stores
    wr(10'h054, 32'h8000_0000, 1'b0, "R5 wr 0x054");
    rd(10'h054, 32'h8000_0000, "R5 no lock on 0x054");
    wr(10'h164, 32'h1234_5678, 1'b0, "R5 wr 0x164");
    rd(10'h164, 32'h1234_5678, "R5 0x164");
    wr(10'h320, 32'hDEAD_BEEF, 1'b0, "R5 wr 0x320");
    rd(10'h320, 32'hDEAD_BEEF, "R5 0x320");

    // R8 unimplemented offsets
    wr(10'h044, 32'h8000_0001, 1'b1, "R8 wr 0x044");
    rd(10'h044, 32'h8000_0001, "R8 0x044 stored");
    wr(10'h200, 32'h0000_0055, 1'b1, "R8 wr 0x200");
    rd(10'h200, 32'h0000_0055, "R8 0x200 stored");

    // R6 out of window
    badAccess(1'b0, 10'h324, "R6 rd 0x324");
    badAccess(1'b0, 10'h3FC, "R6 rd 0x3FC");
    badAccess(1'b1, 10'h3F0, "R6 wr 0x3F0");
    rd(10'h0F0, 32'h0000_0001, "R6 0x0F0 untouched");
    badAccess(1'b1, 10'h324, "R6 wr 0x324");
    badAccess(1'b1, 10'h3FC, "R6 wr 0x3FC");
    rd(10'h0D8, 32'h0000_0000, "R6 0x0D8 untouched");
    rd(10'h0FC, 32'h0000_0000, "R6 0x0FC untouched");
    rd(10'h000, 32'h9000_1000, "R6 0x000 untouched");

    // R7 misaligned
    badAccess(1'b1, 10'h00A, "R7 wr 0x00A");
    rd(10'h008, 32'h0003_5514, "R7 0x008 untouched");
    badAccess(1'b0, 10'h001, "R7 rd 0x001");
    badAccess(1'b1, 10'h0F5, "R7 wr 0x0F5");
    rd(10'h0F4, 32'hFFFE_FFFF, "R7 0x0F4 untouched");

    idle();
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9 all responses seen", expQ.size(), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule